// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages an on-chip packet buffer divided into fixed 256-byte pages. A host writes one-byte commands to it. An allocate command claims a run of contiguous pages and returns a packet number, or reports a failure. Other commands give pages back, put packets on a transmit queue, take packets off the receive queue, or clear state. The receive side of the chip pushes received packet numbers into the receive queue. The transmit side pops packet numbers off the transmit queue.

Each packet number names one slot of a packet table. A slot holds the first page of the packet and its length in pages. A bitmap records which pages are taken. The host sees four things: the head of each queue with an empty flag, the result of the last allocation, the number of free pages, and a busy flag that blocks new commands for a short time after pages are returned.

Top module: `pkt_page_alloc`

## Requirements
- R1: A command is accepted when `cmd_wr` is high at a clock edge and `busy` is low. The opcode sits in bits 7:5 of `cmd_word`: 0 no-op, 1 allocate, 2 reset manager, 3 drop the receive head, 4 release the receive head, 5 free the packet in `pkt_num_reg`, 6 push `pkt_num_reg` onto the transmit queue, 7 reset the transmit queue. A no-op changes no output.
- R2: An allocate command requests (bits 4:0 + 1) pages. It takes the lowest-indexed run of contiguous free pages long enough to hold them, and the lowest unused packet number. `alloc_result` becomes that number with bit 7 clear, and `free_pages` drops by the page count. Both changes are visible in the cycle after the accepting edge.
- R3: An allocate command fails in three cases: no run fits, the request exceeds the buffer, or no packet number is free. A failed allocation sets `alloc_result` to 0x80 and takes no pages.
- R4: `alloc_done` is high for exactly the one cycle after each successful allocation, and stays low after a failed one.
- R5: `queue_heads` holds four fields. Bit 15 is receive-empty, bits 14:8 the receive head number, bit 7 transmit-empty, and bits 6:0 the transmit head number. A head field reads zero while its queue is empty.
- R6: Drop (opcode 3) removes the receive head and leaves its pages allocated.
- R7: Release (opcode 4) removes the receive head and returns its pages to the free pool.
- R8: Free (opcode 5) returns the pages of the packet named by `pkt_num_reg`. If that number is not a live packet, free changes nothing.
- R9: After an accepted release or free, `busy` is high for exactly two cycles. Commands written while `busy` is high are ignored.
- R10: Push (opcode 6) appends `pkt_num_reg` to the transmit queue. A `tx_pop` pulse removes the head, and packets leave in the order they were pushed.
- R11: Reset manager (opcode 2) frees every page, forgets every packet and empties both queues.
- R12: Transmit reset (opcode 7) empties only the transmit queue. Pages and the receive queue keep their state.
- R13: An `rx_push` pulse appends `rx_push_num` to the receive queue, in order.
- R14: After reset, all pages are free, both queues are empty, `busy` is low, `alloc_done` is low and `alloc_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 8 | Opcode in bits 7:5, page count minus one in bits 4:0 |
| pkt_num_reg | input | 7 | Packet number used by the free and push commands |
| rx_push | input | 1 | Receive side appends a packet number |
| rx_push_num | input | 7 | Packet number appended by `rx_push` |
| tx_pop | input | 1 | Transmit side removes the transmit head |
| busy | output | 1 | High while returned pages settle; commands are ignored |
| alloc_result | output | 8 | Last allocated packet number; bit 7 set on failure |
| alloc_done | output | 1 | One-cycle pulse after a successful allocation |
| queue_heads | output | 16 | Receive and transmit heads with empty flags |
| free_pages | output | 4 | Number of free pages |

## Verification
A wrong bit in the page bitmap shows up in `free_pages` in the very next cycle. It also shows up later as an allocation placed at a start page the first-fit rule does not predict. A wrong slot-table entry stays hidden until that packet is freed or released. At that point the count of pages returned, or the place where later allocations land, exposes it. Queue pointer errors appear in `queue_heads` in the cycle after a push, pop or clear. For this reason the checks read the heads after every queue operation, and read the free count after every command.

// File: rtl/pgalloc_pkg.sv
package pgalloc_pkg;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_ALLOC      = 3'd1,
        OP_MGR_RESET  = 3'd2,
        OP_RX_DROP    = 3'd3,
        OP_RX_RELEASE = 3'd4,
        OP_FREE_NUM   = 3'd5,
        OP_TX_PUSH    = 3'd6,
        OP_TX_RESET   = 3'd7
    } pa_op_e;

    localparam int CMD_W      = 8;
    localparam int CMD_OP_LSB = 5;
    localparam int CMD_SIZE_W = 5;

endpackage

// File: rtl/pgalloc_queue.sv
module pgalloc_queue #(
    parameter int DEPTH = 8,
    parameter int DW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd;
        logic [AW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } q_state_t;

    q_state_t st_q, st_d;
    logic     do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CW'(DEPTH)) || do_pop);
        if (clear) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R13
    AST_QUEUE_POP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push && !clear) |=> st_q.cnt == $past(st_q.cnt) - 1'b1); // R10
    AST_QUEUE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty); // R12

endmodule

// File: rtl/pgalloc_fit.sv
module pgalloc_fit #(
    parameter int NUM_PAGES = 8,
    parameter int SIZE_W    = 5
) (
    input  logic [NUM_PAGES-1:0]         used,
    input  logic [SIZE_W-1:0]            size_m1,
    output logic                         found,
    output logic [$clog2(NUM_PAGES)-1:0] start
);
    localparam int SLOT_W = $clog2(NUM_PAGES);

    logic [NUM_PAGES-1:0] fits;

    for (genvar s = 0; s < NUM_PAGES; s++) begin : g_start
        logic [NUM_PAGES-1:0] win;
        always_comb begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                win[p] = (p >= s) && (p <= s + int'(size_m1));
            end
        end
        assign fits[s] = ((s + int'(size_m1)) < NUM_PAGES) && ((win & used) == '0);
    end

    always_comb begin
        found = 1'b0;
        start = '0;
        for (int s = NUM_PAGES - 1; s >= 0; s--) begin
            if (fits[s]) begin
                found = 1'b1;
                start = SLOT_W'(s);
            end
        end
    end

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
    import pgalloc_pkg::*;
#(
    parameter int NUM_PAGES   = 8,
    parameter int PNUM_W      = 7,
    parameter int BUSY_CYCLES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_wr,
    input  logic [7:0]                        cmd_word,
    input  logic [PNUM_W-1:0]                 pkt_num_reg,
    input  logic                              rx_push,
    input  logic [PNUM_W-1:0]                 rx_push_num,
    input  logic                              tx_pop,
    output logic                              busy,
    output logic [PNUM_W:0]                   alloc_result,
    output logic                              alloc_done,
    output logic [2*PNUM_W+1:0]               queue_heads,
    output logic [$clog2(NUM_PAGES+1)-1:0]    free_pages
);
    localparam int SLOT_W = $clog2(NUM_PAGES);
    localparam int FREE_W = $clog2(NUM_PAGES + 1);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [NUM_PAGES-1:0]             used;
        logic [NUM_PAGES-1:0]             live;
        logic [NUM_PAGES-1:0][SLOT_W-1:0] first;
        logic [NUM_PAGES-1:0][SLOT_W-1:0] len_m1;
        logic [PNUM_W:0]                  result;
        logic                             done;
        logic [BUSY_W-1:0]                busy_cnt;
    } pa_state_t;

    pa_state_t st_q, st_d;

    pa_op_e                 op;
    logic                   accept;
    logic [CMD_SIZE_W-1:0]  size_m1;
    logic                   fit_found;
    logic [SLOT_W-1:0]      fit_start;
    logic                   slot_found;
    logic [SLOT_W-1:0]      new_slot;
    logic                   rxq_pop, rxq_clear, txq_push, txq_clear;
    logic                   rx_empty, tx_empty;
    logic [PNUM_W-1:0]      rx_head, tx_head;
    logic                   rel_hit;
    logic [SLOT_W-1:0]      rel_slot;
    logic                   rx_head_ok, pnr_ok;

    function automatic logic [NUM_PAGES-1:0] span(input logic [SLOT_W-1:0] f,
                                                  input logic [SLOT_W-1:0] l);
        logic [NUM_PAGES-1:0] m;
        for (int p = 0; p < NUM_PAGES; p++) begin
            m[p] = (p >= int'(f)) && (p <= int'(f) + int'(l));
        end
        return m;
    endfunction

    assign op         = pa_op_e'(cmd_word[CMD_OP_LSB +: 3]);
    assign size_m1    = cmd_word[CMD_SIZE_W-1:0];
    assign accept     = cmd_wr && (st_q.busy_cnt == '0);
    assign rx_head_ok = int'(rx_head) < NUM_PAGES;
    assign pnr_ok     = int'(pkt_num_reg) < NUM_PAGES;

    pgalloc_fit #(
        .NUM_PAGES (NUM_PAGES),
        .SIZE_W    (CMD_SIZE_W)
    ) fit_i (
        .used    (st_q.used),
        .size_m1 (size_m1),
        .found   (fit_found),
        .start   (fit_start)
    );

    always_comb begin
        slot_found = 1'b0;
        new_slot   = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (!st_q.live[i]) begin
                slot_found = 1'b1;
                new_slot   = SLOT_W'(i);
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy_cnt != '0) st_d.busy_cnt = st_q.busy_cnt - 1'b1;
        rxq_pop   = 1'b0;
        rxq_clear = 1'b0;
        txq_push  = 1'b0;
        txq_clear = 1'b0;
        rel_hit   = 1'b0;
        rel_slot  = '0;
        if (accept) begin
            case (op)
                OP_ALLOC: begin
                    if (fit_found && slot_found) begin
                        st_d.used             = st_q.used | span(fit_start, SLOT_W'(size_m1));
                        st_d.live[new_slot]   = 1'b1;
                        st_d.first[new_slot]  = fit_start;
                        st_d.len_m1[new_slot] = SLOT_W'(size_m1);
                        st_d.result           = {1'b0, PNUM_W'(new_slot)};
                        st_d.done             = 1'b1;
                    end else begin
                        st_d.result = {1'b1, {PNUM_W{1'b0}}};
                    end
                end
                OP_MGR_RESET: begin
                    st_d.used = '0;
                    st_d.live = '0;
                    rxq_clear = 1'b1;
                    txq_clear = 1'b1;
                end
                OP_RX_DROP: rxq_pop = 1'b1;
                OP_RX_RELEASE: begin
                    st_d.busy_cnt = BUSY_W'(BUSY_CYCLES);
                    if (!rx_empty) begin
                        rxq_pop = 1'b1;
                        if (rx_head_ok) begin
                            rel_hit  = 1'b1;
                            rel_slot = rx_head[SLOT_W-1:0];
                        end
                    end
                end
                OP_FREE_NUM: begin
                    st_d.busy_cnt = BUSY_W'(BUSY_CYCLES);
                    if (pnr_ok) begin
                        rel_hit  = 1'b1;
                        rel_slot = pkt_num_reg[SLOT_W-1:0];
                    end
                end
                OP_TX_PUSH:  txq_push  = 1'b1;
                OP_TX_RESET: txq_clear = 1'b1;
                default: ;
            endcase
        end
        if (rel_hit && st_q.live[rel_slot]) begin
            st_d.used           = st_q.used & ~span(st_q.first[rel_slot], st_q.len_m1[rel_slot]);
            st_d.live[rel_slot] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pgalloc_queue #(.DEPTH(NUM_PAGES), .DW(PNUM_W)) rxq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rxq_clear),
        .push      (rx_push),
        .push_data (rx_push_num),
        .pop       (rxq_pop),
        .head      (rx_head),
        .empty     (rx_empty)
    );

    pgalloc_queue #(.DEPTH(NUM_PAGES), .DW(PNUM_W)) txq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (txq_clear),
        .push      (txq_push),
        .push_data (pkt_num_reg),
        .pop       (tx_pop),
        .head      (tx_head),
        .empty     (tx_empty)
    );

    assign busy         = (st_q.busy_cnt != '0);
    assign alloc_result = st_q.result;
    assign alloc_done   = st_q.done;
    assign free_pages   = FREE_W'(NUM_PAGES) - FREE_W'($countones(st_q.used));
    assign queue_heads  = {rx_empty, rx_empty ? {PNUM_W{1'b0}} : rx_head,
                           tx_empty, tx_empty ? {PNUM_W{1'b0}} : tx_head};

    AST_BUSY_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_RX_RELEASE || op == OP_FREE_NUM)) |=> busy); // R9
    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ($stable(free_pages) && !alloc_done)); // R9
    AST_ALLOC_TAKES_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_ALLOC && fit_found && slot_found) |=>
        (int'(free_pages) == int'($past(free_pages)) - int'($past(size_m1)) - 1)); // R2
    AST_DONE_MEANS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done |-> !alloc_result[PNUM_W]); // R4
    AST_MGR_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_MGR_RESET) |=>
        (free_pages == FREE_W'(NUM_PAGES) && queue_heads[2*PNUM_W+1] && queue_heads[PNUM_W])); // R11

endmodule

// File: tb/pkt_page_alloc_tb_top.sv
module pkt_page_alloc_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_word = '0;
    logic [6:0] pkt_num_reg = '0;
    logic       rx_push = 1'b0;
    logic [6:0] rx_push_num = '0;
    logic       tx_pop = 1'b0;
    logic        busy;
    logic [7:0]  alloc_result;
    logic        alloc_done;
    logic [15:0] queue_heads;
    logic [3:0]  free_pages;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pkt_page_alloc dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_word     (cmd_word),
        .pkt_num_reg  (pkt_num_reg),
        .rx_push      (rx_push),
        .rx_push_num  (rx_push_num),
        .tx_pop       (tx_pop),
        .busy         (busy),
        .alloc_result (alloc_result),
        .alloc_done   (alloc_done),
        .queue_heads  (queue_heads),
        .free_pages   (free_pages)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [7:0] w);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_wr   = 1'b0;
        cmd_word = '0;
    endtask

    task automatic push_rx(input logic [6:0] n);
        @(negedge clk);
        rx_push     = 1'b1;
        rx_push_num = n;
        @(negedge clk);
        rx_push     = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R14 free", free_pages, 8);
        chk("R14 heads", queue_heads, 16'h8080);
        chk("R14 busy", busy, 0);
        chk("R14 result", alloc_result, 0);
        chk("R14 done", alloc_done, 0);
    endtask

    task automatic t_alloc_basic();
        do_cmd(8'h21);
        chk("R2 pkt0", alloc_result, 8'h00);
        chk("R2 free after 2", free_pages, 6);
        chk("R4 done high", alloc_done, 1);
        @(negedge clk);
        chk("R4 done one cycle", alloc_done, 0);
        do_cmd(8'h22);
        chk("R2 pkt1", alloc_result, 8'h01);
        chk("R2 free after 3", free_pages, 3);
        do_cmd(8'h23);
        chk("R3 no fit", alloc_result, 8'h80);
        chk("R3 free kept", free_pages, 3);
        chk("R4 no done on fail", alloc_done, 0);
        do_cmd(8'h22);
        chk("R2 pkt2 fills", alloc_result, 8'h02);
        chk("R2 full", free_pages, 0);
    endtask

    task automatic t_free_and_busy();
        pkt_num_reg = 7'd1;
        do_cmd(8'hA0);
        chk("R8 freed pkt1", free_pages, 3);
        chk("R9 busy c1", busy, 1);
        cmd_wr   = 1'b1;
        cmd_word = 8'h20;
        @(negedge clk);
        cmd_wr   = 1'b0;
        cmd_word = '0;
        chk("R9 busy c2", busy, 1);
        @(negedge clk);
        chk("R9 busy ends", busy, 0);
        chk("R9 ignored alloc free", free_pages, 3);
        chk("R9 ignored alloc result", alloc_result, 8'h02);
        pkt_num_reg = 7'd6;
        do_cmd(8'hA0);
        chk("R8 dead number", free_pages, 3);
        wait_cycles(2);
        do_cmd(8'h21);
        chk("R2 lowest slot into hole", alloc_result, 8'h01);
        chk("R2 hole free", free_pages, 1);
        do_cmd(8'h20);
        chk("R2 single page", alloc_result, 8'h03);
        chk("R2 free zero", free_pages, 0);
        do_cmd(8'h29);
        chk("R3 oversize", alloc_result, 8'h80);
    endtask

    task automatic t_rx_queue();
        push_rx(7'd0);
        push_rx(7'd1);
        chk("R13 rx head", queue_heads, 16'h0080);
        do_cmd(8'h60);
        chk("R6 drop head", queue_heads, 16'h0180);
        chk("R6 pages kept", free_pages, 0);
        do_cmd(8'h80);
        chk("R7 release head", queue_heads, 16'h8080);
        chk("R7 pages freed", free_pages, 2);
        wait_cycles(2);
    endtask

    task automatic t_tx_queue();
        push_rx(7'd0);
        pkt_num_reg = 7'd2;
        do_cmd(8'hC0);
        pkt_num_reg = 7'd3;
        do_cmd(8'hC0);
        chk("R10 R5 tx head", queue_heads, 16'h0002);
        pop_tx();
        chk("R10 fifo order", queue_heads, 16'h0003);
        do_cmd(8'hE0);
        chk("R12 tx cleared rx kept", queue_heads, 16'h0080);
        chk("R12 pages kept", free_pages, 2);
        do_cmd(8'h00);
        chk("R1 nop heads", queue_heads, 16'h0080);
        chk("R1 nop free", free_pages, 2);
        chk("R1 nop result", alloc_result, 8'h80);
    endtask

    task automatic t_mgr_reset();
        pkt_num_reg = 7'd2;
        do_cmd(8'hC0);
        do_cmd(8'h40);
        chk("R11 all free", free_pages, 8);
        chk("R11 queues empty", queue_heads, 16'h8080);
        do_cmd(8'h27);
        chk("R11 R2 whole buffer", alloc_result, 8'h00);
        chk("R2 whole free", free_pages, 0);
        do_cmd(8'h20);
        chk("R3 full fail", alloc_result, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_alloc_basic();
        t_free_and_busy();
        t_rx_queue();
        t_tx_queue();
        t_mgr_reset();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule